// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block keeps the controller-wide control state of a four-channel DMA controller: the command byte, an eight-bit status word, a four-bit channel mask, and one mode register per channel. A host writes eight control ports to change that state. The address and count registers elsewhere use a byte-pointer flip-flop, and this block holds it. Separate per-channel inputs let peripherals raise and drop requests. The transfer engine can also report a terminal count through another set of per-channel inputs.

The status word keeps pending requests in its upper nibble, one bit per channel at position channel+4. Its lower nibble holds the terminal-count bits. A channel may be serviced when its mask bit is clear and its request bit is set. The block drives that eligibility vector every cycle, picks the lowest-numbered eligible channel, and presents the decoded mode fields of the picked channel to the transfer engine. All state is registered. Every output follows the registers combinationally, so a write takes effect in the cycle after the clock edge that captures it.

Top module: `dmac_ctl_regs`

## Requirements
- R1: After reset, and in the cycle after a write to port index 5 (master clear), mask_o is 4'b1111 and status_o, command_o, flipflop_o and cmd_err_o are all 0. Master clear takes priority over every other input in the same cycle and leaves the mode registers unchanged. Reset clears the mode registers.
- R2: A write to port index 1 (request) selects a channel with data[1:0]. It sets status bit channel+4 when data[2] is 1 and clears it when data[2] is 0. In either case it clears status bit channel.
- R3: A write to port index 2 (single mask) selects a channel with data[1:0] and loads that channel's mask bit with data[2]. The other mask bits do not change.
- R4: A write to port index 7 loads mask_o from data[3:0]. A write to port index 6 clears all mask bits.
- R5: A write to port index 4 clears flipflop_o and changes nothing else. It takes priority over ptr_toggle_i. When ptr_toggle_i is high without that write, flipflop_o inverts.
- R6: A write to port index 3 stores data[7:2] as the mode of the channel given by data[1:0]. The outputs show the fields of the selected channel: sel_xfer_o is bits 3:2, sel_auto_init_o is bit 4, sel_addr_dec_o is bit 5 and sel_op_mode_o is bits 7:6.
- R7: service_en_o[i] is 1 exactly when mask bit i is 0 and status bit i+4 is 1.
- R8: sel_chan_o is the lowest index set in service_en_o and sel_valid_o is 1. When no channel is eligible, sel_valid_o is 0 and sel_chan_o is 0.
- R9: hold_i[i] sets status bit i+4 and release_i[i] clears it. These inputs are applied after a request write in the same cycle, and release wins over hold.
- R10: A write to port index 0 (command) with only bit 2 allowed to be set loads command_o. A command write with any other bit set leaves command_o unchanged and sets cmd_err_o, which stays set until master clear or reset.
- R11: tc_i[i] sets status bit i. That bit stays set until a request write to channel i or a master clear. When both happen in the same cycle, tc_i wins over the request write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control port write strobe |
| wr_idx | input | 3 | Control port index 0..7 (port offsets 8..15) |
| wr_data | input | 8 | Write data |
| hold_i | input | 4 | Per-channel external request raise |
| release_i | input | 4 | Per-channel external request drop |
| tc_i | input | 4 | Per-channel terminal-count pulse |
| ptr_toggle_i | input | 1 | Byte-pointer toggle from the address/count access |
| command_o | output | 8 | Command register |
| status_o | output | 8 | Requests in [7:4], terminal counts in [3:0] |
| mask_o | output | 4 | Channel mask |
| flipflop_o | output | 1 | Byte-pointer flip-flop |
| cmd_err_o | output | 1 | Sticky unsupported-command flag |
| service_en_o | output | 4 | Eligible channel vector |
| sel_valid_o | output | 1 | A channel is selected |
| sel_chan_o | output | 2 | Selected channel |
| sel_xfer_o | output | 2 | Transfer type of selected channel |
| sel_auto_init_o | output | 1 | Auto-initialise of selected channel |
| sel_addr_dec_o | output | 1 | Address decrement of selected channel |
| sel_op_mode_o | output | 2 | Operating mode of selected channel |

## Verification
The hardest states to reach are the same-cycle collisions. These are a request write against hold and release, a terminal-count pulse against the request write that should clear it, a pointer toggle against a flip-flop clear, and a master clear against a live hold. The stimulus drives each pair in a single cycle. A scoreboard model applies the ordering from the requirements, and the result is compared on the next cycle. Mode retention across master clear is shown by unmasking afterwards, then watching the selected channel's mode fields at the outputs.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;

    localparam int DMAC_CH     = 4;
    localparam int DMAC_DW     = 8;
    localparam int DMAC_CH_W   = $clog2(DMAC_CH);
    localparam int DMAC_PORT_W = 3;
    localparam int DMAC_REQ_BIT = 2;          // set/clear bit of request and single-mask writes
    localparam logic [DMAC_DW-1:0] DMAC_CMD_OK = 8'h04;

    typedef enum logic [DMAC_PORT_W-1:0] {
        PORT_CMD      = 3'd0,
        PORT_REQ      = 3'd1,
        PORT_SMASK    = 3'd2,
        PORT_MODE     = 3'd3,
        PORT_FFCLR    = 3'd4,
        PORT_MCLR     = 3'd5,
        PORT_MASK_CLR = 3'd6,
        PORT_MASK_ALL = 3'd7
    } ctl_port_e;

    typedef struct packed {
        logic cmd;
        logic req;
        logic smask;
        logic mode;
        logic ffclr;
        logic mclr;
        logic mask_clr;
        logic mask_all;
    } ctl_strobe_t;

    // Mode layout matches write data bits 7:2
    typedef struct packed {
        logic [1:0] op_mode;
        logic       addr_dec;
        logic       auto_init;
        logic [1:0] xfer;
    } mode_t;

    function automatic logic cmd_legal(logic [DMAC_DW-1:0] d);
        return (d & ~DMAC_CMD_OK) == '0;
    endfunction

endpackage

// File: rtl/dmac_port_decode.sv
module dmac_port_decode
    import dmac_ctl_pkg::*;
(
    input  logic                   wr_en,
    input  logic [DMAC_PORT_W-1:0] wr_idx,
    output ctl_strobe_t            strb
);
    always_comb begin
        strb = '0;
        if (wr_en) begin
            case (ctl_port_e'(wr_idx))
                PORT_CMD:      strb.cmd      = 1'b1;
                PORT_REQ:      strb.req      = 1'b1;
                PORT_SMASK:    strb.smask    = 1'b1;
                PORT_MODE:     strb.mode     = 1'b1;
                PORT_FFCLR:    strb.ffclr    = 1'b1;
                PORT_MCLR:     strb.mclr     = 1'b1;
                PORT_MASK_CLR: strb.mask_clr = 1'b1;
                PORT_MASK_ALL: strb.mask_all = 1'b1;
                default:       strb          = '0;
            endcase
        end
    end
endmodule

// File: rtl/dmac_mode_bank.sv
module dmac_mode_bank
    import dmac_ctl_pkg::*;
#(
    parameter int N = DMAC_CH,
    localparam int W = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_stb,
    input  logic [DMAC_DW-1:0] wr_data,
    input  logic [W-1:0]       rd_idx,
    output mode_t              rd_mode
);
    mode_t modes [N];

    for (genvar g = 0; g < N; g++) begin : g_mode
        always_ff @(posedge clk) begin
            if (rst)
                modes[g] <= '0;
            else if (wr_stb && (wr_data[W-1:0] == W'(g)))
                modes[g] <= mode_t'(wr_data[DMAC_DW-1:2]);
        end
    end

    assign rd_mode = modes[rd_idx];
endmodule

// File: rtl/dmac_fixed_arb.sv
module dmac_fixed_arb #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         valid,
    output logic [W-1:0] idx
);
    // Scan from the top down so the lowest eligible index is the last to write
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/dmac_ctl_regs.sv
module dmac_ctl_regs
    import dmac_ctl_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [DMAC_PORT_W-1:0] wr_idx,
    input  logic [DMAC_DW-1:0]     wr_data,
    input  logic [DMAC_CH-1:0]     hold_i,
    input  logic [DMAC_CH-1:0]     release_i,
    input  logic [DMAC_CH-1:0]     tc_i,
    input  logic                   ptr_toggle_i,
    output logic [DMAC_DW-1:0]     command_o,
    output logic [2*DMAC_CH-1:0]   status_o,
    output logic [DMAC_CH-1:0]     mask_o,
    output logic                   flipflop_o,
    output logic                   cmd_err_o,
    output logic [DMAC_CH-1:0]     service_en_o,
    output logic                   sel_valid_o,
    output logic [DMAC_CH_W-1:0]   sel_chan_o,
    output logic [1:0]             sel_xfer_o,
    output logic                   sel_auto_init_o,
    output logic                   sel_addr_dec_o,
    output logic [1:0]             sel_op_mode_o
);
    ctl_strobe_t strb;
    logic [DMAC_CH-1:0]   req_q, tc_q, mask_q;
    logic [DMAC_CH-1:0]   req_nxt, tc_nxt, mask_nxt;
    logic [DMAC_DW-1:0]   cmd_q;
    logic                 ff_q, err_q;
    logic [DMAC_CH_W-1:0] wch;
    mode_t                sel_mode;

    assign wch = wr_data[DMAC_CH_W-1:0];

    dmac_port_decode u_dec (
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .strb   (strb)
    );

    always_comb begin
        mask_nxt = mask_q;
        if (strb.smask)    mask_nxt[wch] = wr_data[DMAC_REQ_BIT];
        if (strb.mask_clr) mask_nxt = '0;
        if (strb.mask_all) mask_nxt = wr_data[DMAC_CH-1:0];

        req_nxt = req_q;
        tc_nxt  = tc_q;
        if (strb.req) begin
            req_nxt[wch] = wr_data[DMAC_REQ_BIT];
            tc_nxt[wch]  = 1'b0;
        end
        req_nxt = (req_nxt | hold_i) & ~release_i;
        tc_nxt  = tc_nxt | tc_i;
    end

    always_ff @(posedge clk) begin
        if (rst || strb.mclr) begin
            mask_q <= '1;
            req_q  <= '0;
            tc_q   <= '0;
            cmd_q  <= '0;
            ff_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            mask_q <= mask_nxt;
            req_q  <= req_nxt;
            tc_q   <= tc_nxt;
            if (strb.ffclr)
                ff_q <= 1'b0;
            else if (ptr_toggle_i)
                ff_q <= ~ff_q;
            if (strb.cmd) begin
                if (cmd_legal(wr_data))
                    cmd_q <= wr_data;
                else
                    err_q <= 1'b1;
            end
        end
    end

    assign service_en_o = ~mask_q & req_q;

    dmac_fixed_arb #(.N(DMAC_CH)) u_arb (
        .req   (service_en_o),
        .valid (sel_valid_o),
        .idx   (sel_chan_o)
    );

    dmac_mode_bank #(.N(DMAC_CH)) u_modes (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (strb.mode),
        .wr_data (wr_data),
        .rd_idx  (sel_chan_o),
        .rd_mode (sel_mode)
    );

    assign command_o       = cmd_q;
    assign status_o        = {req_q, tc_q};
    assign mask_o          = mask_q;
    assign flipflop_o      = ff_q;
    assign cmd_err_o       = err_q;
    assign sel_xfer_o      = sel_mode.xfer;
    assign sel_auto_init_o = sel_mode.auto_init;
    assign sel_addr_dec_o  = sel_mode.addr_dec;
    assign sel_op_mode_o   = sel_mode.op_mode;
endmodule

// File: rtl/dmac_ctl_regs_chk.sv
module dmac_ctl_regs_chk
    import dmac_ctl_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [DMAC_PORT_W-1:0] wr_idx,
    input logic [DMAC_DW-1:0]     wr_data,
    input logic [DMAC_CH-1:0]     hold_i,
    input logic [DMAC_CH-1:0]     release_i,
    input logic [DMAC_CH-1:0]     tc_i,
    input logic [DMAC_DW-1:0]     command_o,
    input logic [2*DMAC_CH-1:0]   status_o,
    input logic [DMAC_CH-1:0]     mask_o,
    input logic                   flipflop_o,
    input logic                   cmd_err_o,
    input logic [DMAC_CH-1:0]     service_en_o,
    input logic                   sel_valid_o,
    input logic [DMAC_CH_W-1:0]   sel_chan_o
);
    p_mclr_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == PORT_MCLR) |=>
            (mask_o == '1 && status_o == '0 && command_o == '0 && !flipflop_o && !cmd_err_o));

    p_req_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == PORT_REQ && hold_i == '0 && release_i == '0 && tc_i == '0) |=>
            (status_o[{1'b1, $past(wr_data[1:0])}] == $past(wr_data[2])
             && status_o[{1'b0, $past(wr_data[1:0])}] == 1'b0));

    p_single_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == PORT_SMASK) |=> (mask_o[$past(wr_data[1:0])] == $past(wr_data[2])));

    p_mask_all_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == PORT_MASK_ALL) |=> (mask_o == $past(wr_data[3:0])));

    p_ffclr_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == PORT_FFCLR) |=> !flipflop_o);

    p_masked_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (service_en_o & mask_o) == '0);

    p_sel_lowest_r8: assert property (@(posedge clk) disable iff (rst)
        sel_valid_o |-> (service_en_o[sel_chan_o]
                         && (service_en_o & ((4'b0001 << sel_chan_o) - 4'b0001)) == '0));

    p_sel_none_r8: assert property (@(posedge clk) disable iff (rst)
        !sel_valid_o |-> (service_en_o == '0 && sel_chan_o == '0));

    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        (release_i != '0 && !(wr_en && wr_idx == PORT_MCLR)) |=>
            ((status_o[7:4] & $past(release_i)) == '0));

    p_bad_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == PORT_CMD && !cmd_legal(wr_data)) |=>
            (cmd_err_o && command_o == $past(command_o)));

    p_tc_set_r11: assert property (@(posedge clk) disable iff (rst)
        (tc_i != '0 && !(wr_en && wr_idx == PORT_MCLR)) |=>
            ((status_o[3:0] & $past(tc_i)) == $past(tc_i)));
endmodule

bind dmac_ctl_regs dmac_ctl_regs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .hold_i       (hold_i),
    .release_i    (release_i),
    .tc_i         (tc_i),
    .command_o    (command_o),
    .status_o     (status_o),
    .mask_o       (mask_o),
    .flipflop_o   (flipflop_o),
    .cmd_err_o    (cmd_err_o),
    .service_en_o (service_en_o),
    .sel_valid_o  (sel_valid_o),
    .sel_chan_o   (sel_chan_o)
);

// File: tb/dmac_ctl_regs_tb.sv
module dmac_ctl_regs_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] hold_i = '0, release_i = '0, tc_i = '0;
    logic       ptr_toggle_i = 1'b0;
    logic [7:0] command_o, status_o;
    logic [3:0] mask_o, service_en_o;
    logic       flipflop_o, cmd_err_o, sel_valid_o, sel_auto_init_o, sel_addr_dec_o;
    logic [1:0] sel_chan_o, sel_xfer_o, sel_op_mode_o;

    always #10 clk = ~clk;   // 50 MHz

    dmac_ctl_regs u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .hold_i(hold_i), .release_i(release_i), .tc_i(tc_i), .ptr_toggle_i(ptr_toggle_i),
        .command_o(command_o), .status_o(status_o), .mask_o(mask_o),
        .flipflop_o(flipflop_o), .cmd_err_o(cmd_err_o), .service_en_o(service_en_o),
        .sel_valid_o(sel_valid_o), .sel_chan_o(sel_chan_o), .sel_xfer_o(sel_xfer_o),
        .sel_auto_init_o(sel_auto_init_o), .sel_addr_dec_o(sel_addr_dec_o),
        .sel_op_mode_o(sel_op_mode_o)
    );

    typedef struct {
        string       tag;
        logic [34:0] v;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    // Reference state built from the requirements
    logic [3:0] m_req = '0, m_tc = '0, m_mask = 4'hF;
    logic [7:0] m_cmd = '0;
    logic       m_ff = 1'b0, m_err = 1'b0;
    logic [7:0] m_mode [4] = '{default: 8'h00};

    function automatic logic [34:0] expected_vec();
        logic [3:0] svc;
        logic       val;
        logic [1:0] ch;
        logic [7:0] md;
        svc = ~m_mask & m_req;
        val = 1'b0;
        ch  = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (svc[i]) begin
                val = 1'b1;
                ch  = 2'(i);
            end
        end
        md = m_mode[ch];
        return {m_req, m_tc, m_cmd, m_mask, m_ff, m_err, svc, val, ch,
                md[3:2], md[4], md[5], md[7:6]};
    endfunction

    task automatic step(input string tag, input bit we, input logic [2:0] idx,
                        input logic [7:0] d, input logic [3:0] h, input logic [3:0] r,
                        input logic [3:0] t, input bit tog);
        exp_t e;
        logic [1:0] c;
        @(negedge clk);
        wr_en = we; wr_idx = idx; wr_data = d;
        hold_i = h; release_i = r; tc_i = t; ptr_toggle_i = tog;
        c = d[1:0];
        if (we && idx == 3'd5) begin
            m_mask = 4'hF; m_req = '0; m_tc = '0; m_cmd = '0; m_ff = 1'b0; m_err = 1'b0;
        end else begin
            if (we && idx == 3'd4) m_ff = 1'b0;
            else if (tog)          m_ff = ~m_ff;
            if (we) begin
                case (idx)
                    3'd0: if ((d & 8'hFB) != 0) m_err = 1'b1; else m_cmd = d;
                    3'd1: begin m_req[c] = d[2]; m_tc[c] = 1'b0; end
                    3'd2: m_mask[c] = d[2];
                    3'd3: m_mode[c] = d;
                    3'd6: m_mask = 4'h0;
                    3'd7: m_mask = d[3:0];
                    default: ;
                endcase
            end
            m_req = (m_req | h) & ~r;
            m_tc  = m_tc | t;
        end
        e.tag = tag;
        e.v   = expected_vec();
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b0);
    endtask

    task automatic wr(input string tag, input logic [2:0] idx, input logic [7:0] d);
        step(tag, 1'b1, idx, d, 4'h0, 4'h0, 4'h0, 1'b0);
    endtask

    // Monitor: one comparison per cycle, just after the edge that captured the step
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                logic [34:0] act;
                e   = q.pop_front();
                act = {status_o, command_o, mask_o, flipflop_o, cmd_err_o, service_en_o,
                       sel_valid_o, sel_chan_o, sel_xfer_o, sel_auto_init_o,
                       sel_addr_dec_o, sel_op_mode_o};
                n_checks++;
                if (act !== e.v) begin
                    n_fail++;
                    $display("FAIL %s: actual %09h expected %09h", e.tag, act, e.v);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle("R1 reset state");
        wr("R6 mode ch1 write, none selected", 3'd3, 8'hA5);
        wr("R6 mode ch0 write", 3'd3, 8'h48);
        wr("R4 clear-all mask", 3'd6, 8'hFF);
        wr("R2 R7 R8 request set ch1", 3'd1, 8'h05);
        step("R9 hold ch3", 1'b0, 3'd0, 8'h00, 4'h8, 4'h0, 4'h0, 1'b0);
        wr("R3 single mask set ch1, R8 picks ch3", 3'd2, 8'h05);
        step("R11 tc ch2", 1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 4'h4, 1'b0);
        wr("R11 R2 request clear ch2 drops tc", 3'd1, 8'h02);
        step("R11 tc beats request write", 1'b1, 3'd1, 8'h00, 4'h0, 4'h0, 4'h1, 1'b0);
        step("R9 hold and release ch3 same cycle", 1'b0, 3'd0, 8'h00, 4'h8, 4'h8, 4'h0, 1'b0);
        wr("R3 single mask clear ch1", 3'd2, 8'h01);
        wr("R4 write-all mask upper bits ignored", 3'd7, 8'hF5);
        wr("R10 legal command", 3'd0, 8'h04);
        wr("R10 illegal command", 3'd0, 8'h01);
        wr("R10 sticky error, legal command zero", 3'd0, 8'h00);
        step("R5 toggle", 1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b1);
        step("R5 clear beats toggle", 1'b1, 3'd4, 8'h00, 4'h0, 4'h0, 4'h0, 1'b1);
        step("R5 toggle again", 1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b1);
        wr("R4 clear-all mask again", 3'd6, 8'h00);
        step("R9 release beats request write ch0", 1'b1, 3'd1, 8'h04, 4'h0, 4'h1, 4'h0, 1'b0);
        step("R9 request write ch0 with hold ch2", 1'b1, 3'd1, 8'h04, 4'h4, 4'h0, 4'h0, 1'b0);
        step("R1 master clear beats hold and tc", 1'b1, 3'd5, 8'h00, 4'h2, 4'h0, 4'h8, 1'b1);
        wr("R4 unmask after master clear", 3'd6, 8'h00);
        wr("R6 R8 mode of ch1 kept through master clear", 3'd1, 8'h05);
        wr("R2 request set ch0 takes priority", 3'd1, 8'h04);
        idle("R8 final idle");
        @(negedge clk);
        wait (q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule